// File: doc/BRIEF.md
# Four-Channel PWM Control Register Front End

This block is the register layer between a simple single-cycle bus and a set of PWM channel cores. Software starts and stops channels through two write-one registers: one that only starts and one that only stops. It reads which channels the cores report as running, and collects period-start events from the cores in a register that empties itself when read. Each channel also has a small register window. The window holds a mode word (clock-select code, output polarity and update-target select), a duty value, a duty-update value, a period value and a period-update value. All of these are driven straight to that channel's core. The cores themselves, which generate the waveforms, are outside this block.

Each channel's run control is a two-state machine with states RUN_OFF and RUN_ON. The transition "start" goes from RUN_OFF to RUN_ON when the channel's bit is written as 1 in the enable register. The transition "stop" goes from RUN_ON to RUN_OFF when the channel's bit is written as 1 in the disable register. In every other case the state holds. Reads are registered: a read strobe in one cycle presents its data on the read-data port from the following clock edge, and that value holds until the next read.

Top module: `pwm_regif`

## Requirements
- R1: After reset all channels are in RUN_OFF, every channel register and the event register are zero, and the read data is zero.
- R2: A write to offset 0x04 moves channel n to RUN_ON (ch_run[n] high after the write's clock edge) for every data bit n that is 1; bits that are 0 leave their channels unchanged.
- R3: A write to offset 0x08 moves channel n to RUN_OFF for every data bit n that is 1; bits that are 0 leave their channels unchanged.
- R4: A read of offset 0x0C returns the core_active input in bits 3:0 with all upper bits zero, on the read-data port one clock edge after the read strobe.
- R5: Bit n of the event register (offset 0x1C) is set by a pulse on core_period_start[n]; a read of 0x1C returns the whole register and then clears all of its bits.
- R6: An event pulse in the same cycle as a clearing read is not lost: that read returns the earlier contents, and the new bit is set afterwards.
- R7: Channel n's window starts at 0x200 + n*0x20. Within it, mode is at 0x00, duty at 0x04, duty-update at 0x08, period at 0x0C and period-update at 0x10. Value registers keep the low 16 bits of a write, read back zero-extended, and drive the matching channel output.
- R8: The mode word keeps the clock-select code in bits 3:0, polarity in bit 9 and update-target select in bit 10, with all other bits reading zero. Rewriting the word with only the clock-select code changed leaves polarity as it was.
- R9: Reads of unmapped offsets return zero and writes to them change nothing. This covers misaligned addresses, window offsets 0x14 to 0x1C, addresses at or beyond 0x280, and the write-only offsets 0x04 and 0x08.
- R10: A write to one channel's register changes no other register of that channel and no register of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid from the edge after the read strobe |
| core_active | input | 4 | Per-channel running indication from the cores |
| core_period_start | input | 4 | Per-channel one-cycle period-start pulses |
| ch_run | output | 4 | Per-channel run request (RUN_ON) |
| ch_clksel | output | 16 | Clock-select code, 4 bits per channel |
| ch_polarity | output | 4 | Output polarity per channel |
| ch_upd_sel | output | 4 | Update-target select per channel |
| ch_duty | output | 64 | Duty value, 16 bits per channel |
| ch_duty_upd | output | 64 | Duty-update value, 16 bits per channel |
| ch_period | output | 64 | Period value, 16 bits per channel |
| ch_period_upd | output | 64 | Period-update value, 16 bits per channel |

## Verification
The assertions check on every cycle that the start and stop transitions of each run machine take effect after one edge. They also check that an event pulse always survives into the event register even during a clearing read, and that a clearing read with no new pulse empties it. Three further properties are checked on every cycle: status and unmapped reads return what the port inputs and the map dictate, and channel registers hold still when their channel is not written. The address map, the 16-bit truncation, the mode field layout and the no-effect cases of zero bits and unmapped writes are shown only by the bench's write-then-read scenarios. The same holds for isolation between channels and for the exact value returned by a read that coincides with a pulse.

// File: rtl/pwm_regif_pkg.sv
package pwm_regif_pkg;

    typedef enum logic {
        RUN_OFF = 1'b0,
        RUN_ON  = 1'b1
    } run_state_e;

    localparam int OFS_ENABLE  = 'h004;
    localparam int OFS_DISABLE = 'h008;
    localparam int OFS_STATUS  = 'h00C;
    localparam int OFS_EVENT   = 'h01C;

    localparam int CH_BASE     = 'h200;
    localparam int CH_STRIDE   = 'h020;

    localparam logic [4:0] WIN_MODE    = 5'h00;
    localparam logic [4:0] WIN_DUTY    = 5'h04;
    localparam logic [4:0] WIN_DUTYUPD = 5'h08;
    localparam logic [4:0] WIN_PERIOD  = 5'h0C;
    localparam logic [4:0] WIN_PERUPD  = 5'h10;

    localparam int CLKSEL_W     = 4;
    localparam int MODE_POL_BIT = 9;
    localparam int MODE_UPD_BIT = 10;

endpackage

// File: rtl/pwm_run_fsm.sv
module pwm_run_fsm
    import pwm_regif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic running
);

    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_OFF: if (start && !stop) state_d = RUN_ON;
            RUN_ON:  if (stop)           state_d = RUN_OFF;
            default: state_d = RUN_OFF;
        endcase
    end

    always_comb begin
        running = (state_q == RUN_ON);
    end

    a_r3_stop_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !running);

    a_r2_start_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> running);

endmodule

// File: rtl/pwm_event_reg.sv
module pwm_event_reg #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pulse,
    input  logic           clr,
    output logic [NCH-1:0] evt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt <= '0;
        else        evt <= (clr ? '0 : evt) | pulse;
    end

    a_r6_pulse_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0) |=> ((evt & $past(pulse)) == $past(pulse)));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && pulse == '0) |=> (evt == '0));

endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_regif_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [4:0]          ofs,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic [CLKSEL_W-1:0] clksel,
    output logic                polarity,
    output logic                upd_sel,
    output logic [CW-1:0]       duty,
    output logic [CW-1:0]       duty_upd,
    output logic [CW-1:0]       period,
    output logic [CW-1:0]       period_upd
);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DW-1:CW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clksel     <= '0;
            polarity   <= 1'b0;
            upd_sel    <= 1'b0;
            duty       <= '0;
            duty_upd   <= '0;
            period     <= '0;
            period_upd <= '0;
        end else if (wr) begin
            unique case (ofs)
                WIN_MODE: begin
                    clksel   <= wdata[CLKSEL_W-1:0];
                    polarity <= wdata[MODE_POL_BIT];
                    upd_sel  <= wdata[MODE_UPD_BIT];
                end
                WIN_DUTY:    duty       <= wdata[CW-1:0];
                WIN_DUTYUPD: duty_upd   <= wdata[CW-1:0];
                WIN_PERIOD:  period     <= wdata[CW-1:0];
                WIN_PERUPD:  period_upd <= wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (ofs)
            WIN_MODE: begin
                rdata[CLKSEL_W-1:0] = clksel;
                rdata[MODE_POL_BIT] = polarity;
                rdata[MODE_UPD_BIT] = upd_sel;
            end
            WIN_DUTY:    rdata = DW'(duty);
            WIN_DUTYUPD: rdata = DW'(duty_upd);
            WIN_PERIOD:  rdata = DW'(period);
            WIN_PERUPD:  rdata = DW'(period_upd);
            default:     rdata = '0;
        endcase
    end

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(duty) && $stable(duty_upd) && $stable(period) &&
                 $stable(period_upd) && $stable(clksel) && $stable(polarity) &&
                 $stable(upd_sel)));

endmodule

// File: rtl/pwm_regif.sv
module pwm_regif
    import pwm_regif_pkg::*;
#(
    parameter int AW  = 12,
    parameter int DW  = 32,
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic [NCH-1:0]          core_active,
    input  logic [NCH-1:0]          core_period_start,
    output logic [NCH-1:0]          ch_run,
    output logic [NCH*CLKSEL_W-1:0] ch_clksel,
    output logic [NCH-1:0]          ch_polarity,
    output logic [NCH-1:0]          ch_upd_sel,
    output logic [NCH*CW-1:0]       ch_duty,
    output logic [NCH*CW-1:0]       ch_duty_upd,
    output logic [NCH*CW-1:0]       ch_period,
    output logic [NCH*CW-1:0]       ch_period_upd
);

    localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int WIN_END = CH_BASE + NCH * CH_STRIDE;

    logic            aligned, in_chan;
    logic [IDXW-1:0] ch_idx;
    logic [4:0]      ch_ofs;
    logic            hit_ena, hit_dis, hit_stat, hit_evt;
    logic [NCH-1:0]  start_v, stop_v, evt_q;
    logic [DW-1:0]   crd [NCH];
    logic [DW-1:0]   rd_mux;
    logic            rd_hit;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign in_chan  = aligned && (int'(bus_addr) >= CH_BASE) && (int'(bus_addr) < WIN_END);
    assign ch_idx   = bus_addr[5 +: IDXW];
    assign ch_ofs   = bus_addr[4:0];
    assign hit_ena  = (bus_addr == AW'(OFS_ENABLE));
    assign hit_dis  = (bus_addr == AW'(OFS_DISABLE));
    assign hit_stat = (bus_addr == AW'(OFS_STATUS));
    assign hit_evt  = (bus_addr == AW'(OFS_EVENT));

    assign start_v = (bus_wr && hit_ena) ? bus_wdata[NCH-1:0] : '0;
    assign stop_v  = (bus_wr && hit_dis) ? bus_wdata[NCH-1:0] : '0;

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        pwm_run_fsm u_run (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (start_v[n]),
            .stop    (stop_v[n]),
            .running (ch_run[n])
        );

        pwm_chan_regs #(.DW(DW), .CW(CW)) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (bus_wr && in_chan && (ch_idx == IDXW'(n))),
            .ofs        (ch_ofs),
            .wdata      (bus_wdata),
            .rdata      (crd[n]),
            .clksel     (ch_clksel[n*CLKSEL_W +: CLKSEL_W]),
            .polarity   (ch_polarity[n]),
            .upd_sel    (ch_upd_sel[n]),
            .duty       (ch_duty[n*CW +: CW]),
            .duty_upd   (ch_duty_upd[n*CW +: CW]),
            .period     (ch_period[n*CW +: CW]),
            .period_upd (ch_period_upd[n*CW +: CW])
        );
    end

    pwm_event_reg #(.NCH(NCH)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (core_period_start),
        .clr   (bus_rd && hit_evt),
        .evt   (evt_q)
    );

    always_comb begin
        rd_mux = '0;
        rd_hit = 1'b1;
        if (in_chan)       rd_mux = crd[ch_idx];
        else if (hit_stat) rd_mux = DW'(core_active);
        else if (hit_evt)  rd_mux = DW'(evt_q);
        else               rd_hit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !rd_hit) |=> (bus_rdata == '0));

    a_r4_status_mirrors_cores: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_stat) |=> (bus_rdata == DW'($past(core_active))));

endmodule

// File: tb/pwm_regif_tb_top.sv
`timescale 1ns/1ps
module pwm_regif_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  core_active = '0;
    logic [3:0]  core_period_start = '0;
    logic [3:0]  ch_run;
    logic [15:0] ch_clksel;
    logic [3:0]  ch_polarity;
    logic [3:0]  ch_upd_sel;
    logic [63:0] ch_duty, ch_duty_upd, ch_period, ch_period_upd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_active(core_active), .core_period_start(core_period_start),
        .ch_run(ch_run), .ch_clksel(ch_clksel), .ch_polarity(ch_polarity),
        .ch_upd_sel(ch_upd_sel), .ch_duty(ch_duty), .ch_duty_upd(ch_duty_upd),
        .ch_period(ch_period), .ch_period_upd(ch_period_upd)
    );

    // {op(1: read), addr(12), wdata(32), expected(32), tag(4)}
    localparam int NV = 24;
    localparam logic [80:0] TBL [NV] = '{
        {1'b0, 12'h200, 32'h0000_0603, 32'h0, 4'd8},
        {1'b1, 12'h200, 32'h0,         32'h0000_0603, 4'd8},
        {1'b0, 12'h200, 32'h0000_0605, 32'h0, 4'd8},
        {1'b1, 12'h200, 32'h0,         32'h0000_0605, 4'd8},
        {1'b0, 12'h200, 32'hFFFF_FFFF, 32'h0, 4'd8},
        {1'b1, 12'h200, 32'h0,         32'h0000_060F, 4'd8},
        {1'b0, 12'h204, 32'h1234_5678, 32'h0, 4'd7},
        {1'b1, 12'h204, 32'h0,         32'h0000_5678, 4'd7},
        {1'b0, 12'h228, 32'h0000_AAAA, 32'h0, 4'd7},
        {1'b1, 12'h228, 32'h0,         32'h0000_AAAA, 4'd7},
        {1'b1, 12'h208, 32'h0,         32'h0, 4'd10},
        {1'b0, 12'h26C, 32'h0000_1111, 32'h0, 4'd7},
        {1'b1, 12'h26C, 32'h0,         32'h0000_1111, 4'd7},
        {1'b0, 12'h250, 32'h0000_2222, 32'h0, 4'd7},
        {1'b1, 12'h250, 32'h0,         32'h0000_2222, 4'd7},
        {1'b1, 12'h24C, 32'h0,         32'h0, 4'd10},
        {1'b0, 12'h214, 32'h0000_FFFF, 32'h0, 4'd9},
        {1'b1, 12'h214, 32'h0,         32'h0, 4'd9},
        {1'b0, 12'h280, 32'h0000_FFFF, 32'h0, 4'd9},
        {1'b1, 12'h280, 32'h0,         32'h0, 4'd9},
        {1'b0, 12'h205, 32'h0000_7777, 32'h0, 4'd9},
        {1'b1, 12'h204, 32'h0,         32'h0000_5678, 4'd9},
        {1'b1, 12'h004, 32'h0,         32'h0, 4'd9},
        {1'b1, 12'h210, 32'h0,         32'h0, 4'd7}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [3:0] p);
        @(negedge clk);
        core_period_start = p;
        @(negedge clk);
        core_period_start = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 run", {60'b0, ch_run}, 64'h0);
        chk("R1 rdata", {32'b0, bus_rdata}, 64'h0);
        chk("R1 duty", ch_duty, 64'h0);
        do_read(12'h01C, rd);
        chk("R1 event", {32'b0, rd}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i][80]) begin
                do_read(TBL[i][79:68], rd);
                chk(tag_name(TBL[i][3:0]), {32'b0, rd}, {32'b0, TBL[i][35:4]});
            end else begin
                do_write(TBL[i][79:68], TBL[i][67:36]);
            end
        end

        // R7 R8 outputs to cores
        chk("R8 clksel", {48'b0, ch_clksel}, 64'h000F);
        chk("R8 polarity", {60'b0, ch_polarity}, 64'h1);
        chk("R8 upd_sel", {60'b0, ch_upd_sel}, 64'h1);
        chk("R7 duty out", {48'b0, ch_duty[15:0]}, 64'h5678);
        chk("R7 dutyupd out", ch_duty_upd, 64'h0000_0000_AAAA_0000);
        chk("R7 period out", ch_period, 64'h1111_0000_0000_0000);
        chk("R10 period_upd out", ch_period_upd, 64'h0000_2222_0000_0000);

        // R2 / R3 run control
        do_write(12'h004, 32'h5);
        chk("R2 start", {60'b0, ch_run}, 64'h5);
        do_write(12'h004, 32'h0);
        chk("R2 zero bits", {60'b0, ch_run}, 64'h5);
        do_write(12'h004, 32'h2);
        chk("R2 add", {60'b0, ch_run}, 64'h7);
        do_write(12'h008, 32'h4);
        chk("R3 stop", {60'b0, ch_run}, 64'h3);
        do_write(12'h008, 32'h0);
        chk("R3 zero bits", {60'b0, ch_run}, 64'h3);
        do_write(12'h00C, 32'hF);
        chk("R9 status write", {60'b0, ch_run}, 64'h3);

        // R4 status
        core_active = 4'b1010;
        do_read(12'h00C, rd);
        chk("R4 status", {32'b0, rd}, 64'hA);
        core_active = 4'b0001;
        do_read(12'h00C, rd);
        chk("R4 status2", {32'b0, rd}, 64'h1);

        // R5 events
        pulse(4'b0001);
        pulse(4'b1000);
        do_read(12'h01C, rd);
        chk("R5 collect", {32'b0, rd}, 64'h9);
        do_read(12'h01C, rd);
        chk("R5 cleared", {32'b0, rd}, 64'h0);

        // R6 pulse during clearing read
        pulse(4'b0010);
        @(negedge clk);
        bus_addr = 12'h01C; bus_rd = 1'b1; core_period_start = 4'b0100;
        @(negedge clk);
        bus_rd = 1'b0; core_period_start = '0;
        chk("R6 old value", {32'b0, bus_rdata}, 64'h2);
        do_read(12'h01C, rd);
        chk("R6 kept", {32'b0, rd}, 64'h4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule